// File: doc/BRIEF.md
# General-Purpose Pin Register Bank

This block sits behind a serial-bus front end and controls a group of general-purpose pins through four byte-wide registers. The registers hold captured pin levels, output values, per-bit read inversion and per-bit direction. The front end presents a 2-bit register index with a write strobe or a read strobe. The bank answers each read one cycle later with a data byte and a valid flag. Toward the pads it drives a value and an output enable for every pin, and it takes the sampled pin levels back in.

Pins whose bit is set in `OD_MASK` (bit 0 by default) behave as open-drain. They can pull low or release, and they never drive high. The pin levels are captured when the input register is read, so each read returns one coherent byte. Polarity inversion is applied to that byte as it is returned.

A small access sequencer governs reads. It has two states. `ACC_IDLE` is the rest state. `ACC_REPLY` presents the read byte for one cycle. The transitions are: idle-to-reply on a read strobe, reply-to-reply on a back-to-back read strobe, reply-to-idle when no strobe follows, and idle-to-idle otherwise. Writes do not change the state.

Top module: `gpio_port_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, the registers hold their defaults: output 00h, polarity F0h and direction FFh. All `pin_oe` bits are 0 and `pin_out` is 00h.
- R2: Index 1 selects the output register, 2 selects the polarity register and 3 selects the direction register. A write to any of these is returned by a later read of the same index.
- R3: A read strobe with index 0 captures `pin_in` at the strobe's clock edge. The reply is the captured byte XOR the polarity register. A pin change after that edge does not alter the reply.
- R4: A write with index 0 has no effect on any register or pin.
- R5: A read of index 1 returns the stored output byte, whatever the levels on `pin_in`.
- R6: A pin whose direction bit is 1 has `pin_oe`=0 and `pin_out`=0, even though its output bit stays stored. A pin that is not open-drain and has direction bit 0 has `pin_oe`=1 and `pin_out` equal to its output bit.
- R7: An open-drain pin never has `pin_out`=1. With direction bit 0, its `pin_oe` is 1 only while its output bit is 0.
- R8: `pin_out` and `pin_oe` keep their old values during the cycle a write strobe is high. They show the new values from the next cycle on.
- R9: `rd_valid` is high for exactly the cycle after each read strobe. `rd_data` is 00h whenever `rd_valid` is low.
- R10: When `rd_stb` and `wr_stb` are high in the same cycle, the read is served and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Register index for the current strobe |
| wr_stb | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, one cycle |
| rd_data | output | 8 | Read reply, 00h when not valid |
| rd_valid | output | 1 | Reply valid |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Output enable for each pad |

## Verification
The assertions check the following on every cycle:
- an enabled pad always has its direction bit cleared, and open-drain pads never drive high;
- each read strobe gets exactly one valid reply in the next cycle;
- the register state stays unchanged after a write to index 0 or a write that collides with a read.

Only the bench scenarios can show the rest:
- the value relationships: reset defaults, polarity applied to captured levels, and output readback that ignores the pins;
- capture coherence when the pins change after the strobe;
- the one-cycle delay between a write and its effect on the pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned IDX_W = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_INPUT     = 2'd0,
        IDX_OUTPUT    = 2'd1,
        IDX_POLARITY  = 2'd2,
        IDX_DIRECTION = 2'd3
    } reg_idx_e;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_REPLY = 1'b1
    } acc_state_e;

endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int unsigned      W       = 8,
    parameter logic [W-1:0]     OUT_RST = '0,
    parameter logic [W-1:0]     POL_RST = '0,
    parameter logic [W-1:0]     DIR_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_idx_e     wr_idx,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
            pol_q <= POL_RST;
            dir_q <= DIR_RST;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_OUTPUT:    out_q <= wr_data;
                IDX_POLARITY:  pol_q <= wr_data;
                IDX_DIRECTION: dir_q <= wr_data;
                IDX_INPUT:     ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_input_capture.sv
module gpio_input_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] pol_q,
    output logic [W-1:0] in_view
);

    logic [W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_q <= '0;
        else if (cap_en) cap_q <= pin_in;
    end

    assign in_view = cap_q ^ pol_q;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] OD_MASK = 'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pad
        if (OD_MASK[i]) begin : g_od
            assign pin_oe[i]  = ~dir_q[i] & ~out_q[i];
            assign pin_out[i] = 1'b0;
        end else begin : g_pp
            assign pin_oe[i]  = ~dir_q[i];
            assign pin_out[i] = ~dir_q[i] & out_q[i];
        end
    end

    // R6
    oe_needs_output_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R7
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & OD_MASK) == '0);

endmodule

// File: rtl/gpio_access_fsm.sv
module gpio_access_fsm
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic         wr_stb,
    input  reg_idx_e     idx,
    input  logic [W-1:0] in_view,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] pol_q,
    input  logic [W-1:0] dir_q,
    output logic         wr_en,
    output logic         cap_en,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);

    acc_state_e state_q, state_d;
    reg_idx_e   idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            idx_q   <= IDX_INPUT;
        end else begin
            state_q <= state_d;
            if (rd_stb) idx_q <= idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  state_d = rd_stb ? ACC_REPLY : ACC_IDLE;
            ACC_REPLY: state_d = rd_stb ? ACC_REPLY : ACC_IDLE;
        endcase
    end

    always_comb begin
        wr_en    = wr_stb & ~rd_stb & (idx != IDX_INPUT);
        cap_en   = rd_stb & (idx == IDX_INPUT);
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_REPLY: begin
                rd_valid = 1'b1;
                unique case (idx_q)
                    IDX_INPUT:     rd_data = in_view;
                    IDX_OUTPUT:    rd_data = out_q;
                    IDX_POLARITY:  rd_data = pol_q;
                    IDX_DIRECTION: rd_data = dir_q;
                endcase
            end
        endcase
    end

    // R9
    reply_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R9
    reply_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb));

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] OD_MASK = 8'h01,
    parameter logic [W-1:0] OUT_RST = 8'h00,
    parameter logic [W-1:0] POL_RST = 8'hF0,
    parameter logic [W-1:0] DIR_RST = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             wr_stb,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_stb,
    output logic [W-1:0]     rd_data,
    output logic             rd_valid,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);

    reg_idx_e     idx;
    logic         wr_en, cap_en;
    logic [W-1:0] out_q, pol_q, dir_q, in_view;

    assign idx = reg_idx_e'(reg_idx);

    gpio_access_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .idx(idx),
        .in_view(in_view), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
        .wr_en(wr_en), .cap_en(cap_en), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    gpio_reg_file #(.W(W), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .DIR_RST(DIR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_data(wr_data),
        .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q)
    );

    gpio_input_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pin_in(pin_in),
        .pol_q(pol_q), .in_view(in_view)
    );

    gpio_pad_drive #(.W(W), .OD_MASK(OD_MASK)) u_pad (
        .clk(clk), .rst_n(rst_n), .out_q(out_q), .dir_q(dir_q),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R4
    input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && reg_idx == IDX_INPUT)
        |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

    // R10
    collision_drops_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

endmodule

// File: tb/gpio_port_bank_tb.sv
module gpio_port_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    gpio_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .rd_valid(rd_valid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected replies as the design produces them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected reply: actual=%02h expected=none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check8(t, rd_data, e);
            end
        end
    end

    task automatic do_write(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] idx, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_idx = idx; rd_stb = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic check_pins(input string tag, input logic [7:0] eoe, input logic [7:0] eout);
        check8({tag, " oe"}, pin_oe, eoe);
        check8({tag, " out"}, pin_out, eout);
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_pins("R1 held", 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_pins("R1 released", 8'h00, 8'h00);
        do_read(2'd1, 8'h00, "R1 output default");
        do_read(2'd2, 8'hF0, "R1 polarity default");
        do_read(2'd3, 8'hFF, "R1 direction default");
        // R9 idle reply bus
        @(negedge clk);
        check8("R9 idle valid", {7'd0, rd_valid}, 8'h00);
        check8("R9 idle data", rd_data, 8'h00);

        // R3 polarity on captured input
        pin_in = 8'hA5;
        do_read(2'd0, 8'h55, "R3 input with default polarity");
        do_write(2'd2, 8'h00);
        pin_in = 8'h3C;
        do_read(2'd0, 8'h3C, "R3 input no inversion");
        do_write(2'd2, 8'hFF);
        do_read(2'd0, 8'hC3, "R3 input full inversion");
        // R3 coherence: pins change after capture edge
        @(negedge clk);
        reg_idx = 2'd0; rd_stb = 1'b1; pin_in = 8'h0F;
        exp_q.push_back(8'hF0); tag_q.push_back("R3 coherent capture");
        @(posedge clk); #1 pin_in = 8'hF0;
        @(negedge clk); rd_stb = 1'b0;

        // R4 write to input index ignored
        do_write(2'd0, 8'h77);
        check_pins("R4 pins after input write", 8'h00, 8'h00);
        do_read(2'd1, 8'h00, "R4 output unchanged");
        do_read(2'd2, 8'hFF, "R4 polarity unchanged");
        do_read(2'd3, 8'hFF, "R4 direction unchanged");
        do_read(2'd0, 8'h0F, "R4 input still live");

        // R2 / R8 / R6
        do_write(2'd1, 8'hA6);
        check_pins("R6 outputs stored while inputs", 8'h00, 8'h00);
        @(negedge clk);
        reg_idx = 2'd3; wr_data = 8'h00; wr_stb = 1'b1;
        #1 check_pins("R8 before edge", 8'h00, 8'h00);
        @(negedge clk); wr_stb = 1'b0;
        check_pins("R8 after edge", 8'hFF, 8'hA6);
        do_read(2'd1, 8'hA6, "R2 output readback");
        do_read(2'd3, 8'h00, "R2 direction readback");
        do_write(2'd2, 8'h5A);
        do_read(2'd2, 8'h5A, "R2 polarity readback");

        // R5 readback is latch, not pin
        pin_in = 8'h00;
        do_read(2'd1, 8'hA6, "R5 output latch vs pins");
        do_read(2'd0, 8'h5A, "R5 input reflects pins on outputs");

        // R7 open-drain release
        do_write(2'd1, 8'hFF);
        check_pins("R7 open-drain released", 8'hFE, 8'hFE);
        // R6 mixed direction
        do_write(2'd3, 8'hF0);
        check_pins("R6 mixed direction", 8'h0E, 8'h0E);
        do_read(2'd1, 8'hFF, "R6 stored output bits");

        // R10 collision
        @(negedge clk);
        reg_idx = 2'd3; wr_data = 8'h55; wr_stb = 1'b1; rd_stb = 1'b1;
        exp_q.push_back(8'hF0); tag_q.push_back("R10 collision read");
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
        do_read(2'd3, 8'hF0, "R10 write dropped");
        check_pins("R10 pins unchanged", 8'h0E, 8'h0E);

        // R1 reset mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_pins("R1 reset again", 8'h00, 8'h00);
        rst_n = 1'b1;
        do_read(2'd2, 8'hF0, "R1 polarity after reset");
        do_read(2'd3, 8'hFF, "R1 direction after reset");

        repeat (3) @(negedge clk);
        check8("R9 all replies seen", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule